// File: doc/BRIEF.md
# Interrupt Status and Cause Control

This block is the interrupt side of a small coprocessor for a 32-bit pipelined core. It keeps a status word, a cause word, an exception return address and a handler base address. Up to eight level-sensitive interrupt lines are copied into pending bits of the cause word on every clock. From these the block forms one request signal. The signal is on when interrupts are globally enabled, the core is not already inside an exception, and at least one pending line is unmasked.

The core reports each instruction fetch to the block. A fetch that carries no exception of its own, while the request is on, becomes an interrupt exception. The block then stores the fetch address as the return address. If the handler base is nonzero, it sets the exception-level flag and steers the program counter to that base. A fetch that carries another exception records its five-bit code in the cause word instead. A return-from-exception pulse steers the program counter back to the stored address and clears the exception-level flag. A four-entry register port gives software read and write access to all four words.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset, status reads 0x0000FF01 (bit 0 global enable = 1, bit 1 exception level = 0, bits 15:8 line masks all 1). Cause, return address and handler base read 0. `irq_req` is 0.
- R2: Interrupt line n is copied into cause bit 8+n at each rising clock edge. It is visible on the read port one edge after it is driven. Cause bits 15:8 above the configured line count read 0.
- R3: `irq_req` is 1 exactly when status bit 0 is 1, status bit 1 is 0, and the AND of status bits 15:8 with cause bits 15:8 is nonzero. It is combinational from the stored words.
- R4: `take_irq` is 1 in a cycle with `fetch_valid`=1, `fetch_other_exc`=0, `eret`=0 and `irq_req`=1. At that edge, the return address takes `fetch_pc`.
- R5: On a taken interrupt with a nonzero handler base, `redirect_valid`=1 and `redirect_pc` equals the handler base in the same cycle, and status bit 1 is set at the edge. With a handler base of 0 there is no redirect and status bit 1 is left unchanged.
- R6: A valid fetch with `fetch_other_exc`=1 is never taken as an interrupt. It writes `fetch_exc_code` into cause bits 6:2 and `fetch_pc` into the return address. A taken interrupt leaves cause bits 6:2 unchanged.
- R7: `eret`=1 gives `redirect_valid`=1 with `redirect_pc` equal to the stored return address, and clears status bit 1 at the edge. A fetch in the same cycle is ignored: no interrupt is taken and the return address is unchanged.
- R8: Register select encoding is 0 status, 1 cause, 2 return address, 3 handler base. Reads are combinational. A write stores the full word, except that cause bits 15:8 ignore software and keep following the lines.
- R9: When a software write and a hardware update touch the same field at one edge, the hardware update wins. This covers status bit 1 on interrupt entry and the return address on an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines |
| reg_sel | input | 2 | Register select for read and write |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| fetch_valid | input | 1 | A fetch is offered this cycle |
| fetch_pc | input | DATA_W | Address of the fetched instruction |
| fetch_other_exc | input | 1 | The fetch already carries a non-interrupt exception |
| fetch_exc_code | input | 5 | Code of that non-interrupt exception |
| eret | input | 1 | Return-from-exception executes this cycle |
| irq_req | output | 1 | Interrupt request to the core |
| take_irq | output | 1 | This fetch becomes an interrupt exception |
| redirect_valid | output | 1 | Program counter must be replaced this cycle |
| redirect_pc | output | DATA_W | Replacement program counter |

## Verification
The hardest situations to reach are the single-edge collisions. In one, a taken interrupt meets a software write of the status word that would leave the exception flag clear. In another, an exception meets a software write of the return address. In a third, a return-from-exception meets a fetch while a line is still pending. The bench reaches each of these by holding a line asserted until its pending bit is captured. It then drives the fetch, the write strobe and, where needed, `eret` in the same half period. Afterwards it reads back the status word and the return address through the register port to see which update won.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_CAUSE  = 2'd1,
      SEL_EPC    = 2'd2,
      SEL_EBASE  = 2'd3
   } csr_sel_e;

   localparam int IE_BIT    = 0;
   localparam int EXL_BIT   = 1;
   localparam int CODE_LSB  = 2;
   localparam int CODE_W    = 5;
   localparam int MASK_LSB  = 8;
   localparam int FIELD_W   = 8;
endpackage

// File: rtl/irq_pending_latch.sv
module irq_pending_latch #(
   parameter int NUM_LINES = 8,
   parameter int FIELD_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   output logic [FIELD_W-1:0]   pending_o
);
   for (genvar g = 0; g < FIELD_W; g++) begin : g_bit
      if (g < NUM_LINES) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pending_o[g] <= 1'b0;
            else        pending_o[g] <= lines_i[g];
         end
      end else begin : g_tied
         assign pending_o[g] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_request_gen.sv
module irq_request_gen #(
   parameter int FIELD_W = 8,
   parameter bit GATE_IE = 1'b1
) (
   input  logic               ie_i,
   input  logic               exl_i,
   input  logic [FIELD_W-1:0] mask_i,
   input  logic [FIELD_W-1:0] pending_i,
   output logic               req_o
);
   logic any_unmasked;
   assign any_unmasked = |(mask_i & pending_i);

   if (GATE_IE) begin : g_gated
      assign req_o = ie_i & ~exl_i & any_unmasked;
   end else begin : g_ungated
      assign req_o = ~exl_i & any_unmasked;
   end
endmodule

// File: rtl/irq_event_sel.sv
module irq_event_sel #(
   parameter int DATA_W = 32
) (
   input  logic              fetch_valid_i,
   input  logic              fetch_other_i,
   input  logic              eret_i,
   input  logic              req_i,
   input  logic [DATA_W-1:0] ebase_i,
   input  logic [DATA_W-1:0] epc_i,
   output logic              take_irq_o,
   output logic              take_other_o,
   output logic              set_exl_o,
   output logic              clr_exl_o,
   output logic              redirect_valid_o,
   output logic [DATA_W-1:0] redirect_pc_o
);
   logic ebase_set;
   assign ebase_set = |ebase_i;

   always_comb begin
      take_irq_o       = fetch_valid_i & ~fetch_other_i & ~eret_i & req_i;
      take_other_o     = fetch_valid_i &  fetch_other_i & ~eret_i;
      set_exl_o        = take_irq_o & ebase_set;
      clr_exl_o        = eret_i;
      redirect_valid_o = eret_i | set_exl_o;
      redirect_pc_o    = eret_i ? epc_i : ebase_i;
   end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit #(
   parameter int DATA_W    = 32,
   parameter int NUM_LINES = 8,
   parameter bit GATE_IE   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [1:0]           reg_sel,
   input  logic                 reg_wr_en,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic                 fetch_valid,
   input  logic [DATA_W-1:0]    fetch_pc,
   input  logic                 fetch_other_exc,
   input  logic [4:0]           fetch_exc_code,
   input  logic                 eret,
   output logic                 irq_req,
   output logic                 take_irq,
   output logic                 redirect_valid,
   output logic [DATA_W-1:0]    redirect_pc
);
   import irq_ctrl_pkg::*;

   localparam int HI_W = DATA_W - MASK_LSB - FIELD_W;
   localparam logic [DATA_W-1:0] STATUS_RST =
      DATA_W'({FIELD_W{1'b1}}) << MASK_LSB | DATA_W'(1) << IE_BIT;
   localparam logic [DATA_W-1:0] PEND_FIELD =
      DATA_W'({FIELD_W{1'b1}}) << MASK_LSB;

   if (DATA_W < MASK_LSB + FIELD_W) begin : g_bad_width
      $error("irq_ctrl_unit: DATA_W too small for the mask field");
   end
   if (NUM_LINES < 1 || NUM_LINES > FIELD_W) begin : g_bad_lines
      $error("irq_ctrl_unit: NUM_LINES must lie in 1..8");
   end

   csr_sel_e              sel;
   logic [DATA_W-1:0]     status_q, cause_sw_q, epc_q, ebase_q, cause_view;
   logic [FIELD_W-1:0]    pending;
   logic                  take_other, set_exl, clr_exl;

   assign sel = csr_sel_e'(reg_sel);

   irq_pending_latch #(.NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .pending_o(pending));

   assign cause_view = cause_sw_q |
      {{HI_W{1'b0}}, pending, {MASK_LSB{1'b0}}};

   irq_request_gen #(.FIELD_W(FIELD_W), .GATE_IE(GATE_IE)) u_req (
      .ie_i(status_q[IE_BIT]), .exl_i(status_q[EXL_BIT]),
      .mask_i(status_q[MASK_LSB +: FIELD_W]), .pending_i(pending),
      .req_o(irq_req));

   irq_event_sel #(.DATA_W(DATA_W)) u_evt (
      .fetch_valid_i(fetch_valid), .fetch_other_i(fetch_other_exc),
      .eret_i(eret), .req_i(irq_req), .ebase_i(ebase_q), .epc_i(epc_q),
      .take_irq_o(take_irq), .take_other_o(take_other),
      .set_exl_o(set_exl), .clr_exl_o(clr_exl),
      .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc));

   // software write first, hardware events override touched fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= STATUS_RST;
         cause_sw_q <= '0;
         epc_q      <= '0;
         ebase_q    <= '0;
      end else begin
         if (reg_wr_en) begin
            case (sel)
               SEL_STATUS: status_q   <= reg_wdata;
               SEL_CAUSE:  cause_sw_q <= reg_wdata & ~PEND_FIELD;
               SEL_EPC:    epc_q      <= reg_wdata;
               SEL_EBASE:  ebase_q    <= reg_wdata;
               default:    ;
            endcase
         end
         if (set_exl) status_q[EXL_BIT] <= 1'b1;
         if (clr_exl) status_q[EXL_BIT] <= 1'b0;
         if (take_other) cause_sw_q[CODE_LSB +: CODE_W] <= fetch_exc_code;
         if (take_irq || take_other) epc_q <= fetch_pc;
      end
   end

   always_comb begin
      case (sel)
         SEL_STATUS: reg_rdata = status_q;
         SEL_CAUSE:  reg_rdata = cause_view;
         SEL_EPC:    reg_rdata = epc_q;
         default:    reg_rdata = ebase_q;
      endcase
   end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
   parameter int DATA_W    = 32,
   parameter int NUM_LINES = 8,
   parameter bit GATE_IE   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic [DATA_W-1:0]    fetch_pc,
   input logic                 fetch_other_exc,
   input logic                 eret,
   input logic                 irq_req,
   input logic                 take_irq,
   input logic [DATA_W-1:0]    status_q,
   input logic [DATA_W-1:0]    cause_view,
   input logic [DATA_W-1:0]    epc_q,
   input logic [DATA_W-1:0]    ebase_q
);
   import irq_ctrl_pkg::*;

   assert_pending_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cause_view[MASK_LSB +: NUM_LINES] == $past(irq_lines));

   assert_exl_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[EXL_BIT] |-> !irq_req);

   if (GATE_IE) begin : g_ie_chk
      assert_ie_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !status_q[IE_BIT] |-> !irq_req);
   end

   assert_epc_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> epc_q == $past(fetch_pc));

   assert_exl_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && ebase_q != '0) |=> status_q[EXL_BIT]);

   assert_other_exc_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_other_exc |-> !take_irq);

   assert_eret_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eret |=> !status_q[EXL_BIT]);
endmodule

bind irq_ctrl_unit irq_ctrl_checker #(
   .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .GATE_IE(GATE_IE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .fetch_pc(fetch_pc),
   .fetch_other_exc(fetch_other_exc), .eret(eret), .irq_req(irq_req),
   .take_irq(take_irq), .status_q(status_q), .cause_view(cause_view),
   .epc_q(epc_q), .ebase_q(ebase_q)
);

// File: tb/irq_ctrl_unit_test.sv
module irq_ctrl_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_lines = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_other_exc = 1'b0;
   logic [4:0]  fetch_exc_code = '0;
   logic        eret = 1'b0;
   logic        irq_req, take_irq, redirect_valid;
   logic [31:0] redirect_pc;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctrl_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_sel(reg_sel),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_other_exc(fetch_other_exc), .fetch_exc_code(fetch_exc_code),
      .eret(eret), .irq_req(irq_req), .take_irq(take_irq),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] val);
      reg_sel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      #1;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); chk("R1 status", v, 32'h0000FF01);
      rd(2'd1, v); chk("R1 cause", v, 32'h0);
      rd(2'd2, v); chk("R1 epc", v, 32'h0);
      rd(2'd3, v); chk("R1 ebase", v, 32'h0);
      chk("R1 irq_req", {31'b0, irq_req}, 32'h0);
   endtask

   task automatic t_pending();
      logic [31:0] v;
      @(negedge clk); irq_lines = 8'hA5;
      step();
      rd(2'd1, v); chk("R2 cause pending", v, 32'h0000A500);
      chk("R3 req unmasked", {31'b0, irq_req}, 32'h1);
      @(negedge clk); irq_lines = 8'h00;
      step();
      rd(2'd1, v); chk("R2 cause cleared", v, 32'h0);
      chk("R3 req idle", {31'b0, irq_req}, 32'h0);
   endtask

   task automatic t_mask();
      wr(2'd0, 32'h00000201);
      @(negedge clk); irq_lines = 8'h01;
      step();
      chk("R3 masked line", {31'b0, irq_req}, 32'h0);
      @(negedge clk); irq_lines = 8'h02;
      step();
      chk("R3 enabled line", {31'b0, irq_req}, 32'h1);
      wr(2'd0, 32'h00000200);
      chk("R3 ie clear", {31'b0, irq_req}, 32'h0);
      wr(2'd0, 32'h0000FF03);
      chk("R3 exl set", {31'b0, irq_req}, 32'h0);
      wr(2'd0, 32'h0000FF01);
      chk("R3 restored", {31'b0, irq_req}, 32'h1);
      @(negedge clk); irq_lines = 8'h00;
      step();
   endtask

   task automatic t_take_ebase();
      logic [31:0] v;
      wr(2'd3, 32'h80000180);
      @(negedge clk); irq_lines = 8'h01;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_pc = 32'h00400010;
      #1;
      chk("R4 take", {31'b0, take_irq}, 32'h1);
      chk("R5 redirect valid", {31'b0, redirect_valid}, 32'h1);
      chk("R5 redirect pc", redirect_pc, 32'h80000180);
      @(negedge clk); fetch_valid = 1'b0;
      #1;
      chk("R5 req after entry", {31'b0, irq_req}, 32'h0);
      rd(2'd0, v); chk("R5 exl set", v, 32'h0000FF03);
      rd(2'd2, v); chk("R4 epc", v, 32'h00400010);
      // return while a fetch is offered and the line still pending
      @(negedge clk);
      eret = 1'b1; fetch_valid = 1'b1; fetch_pc = 32'h00401234;
      #1;
      chk("R7 redirect valid", {31'b0, redirect_valid}, 32'h1);
      chk("R7 redirect pc", redirect_pc, 32'h00400010);
      chk("R7 no take", {31'b0, take_irq}, 32'h0);
      @(negedge clk); eret = 1'b0; fetch_valid = 1'b0;
      #1;
      rd(2'd0, v); chk("R7 exl cleared", v, 32'h0000FF01);
      rd(2'd2, v); chk("R7 epc kept", v, 32'h00400010);
      chk("R7 req again", {31'b0, irq_req}, 32'h1);
      @(negedge clk); irq_lines = 8'h00;
      step();
   endtask

   task automatic t_take_no_ebase();
      logic [31:0] v;
      wr(2'd3, 32'h0);
      @(negedge clk); irq_lines = 8'h80;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_pc = 32'h00400100;
      #1;
      chk("R4 take zero base", {31'b0, take_irq}, 32'h1);
      chk("R5 no redirect", {31'b0, redirect_valid}, 32'h0);
      @(negedge clk); fetch_valid = 1'b0;
      #1;
      rd(2'd0, v); chk("R5 exl untouched", v, 32'h0000FF01);
      rd(2'd2, v); chk("R4 epc zero base", v, 32'h00400100);
      rd(2'd1, v); chk("R6 code unchanged", v, 32'h00008000);
      @(negedge clk); irq_lines = 8'h00;
      step();
   endtask

   task automatic t_other_exc();
      logic [31:0] v;
      @(negedge clk); irq_lines = 8'h01;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_other_exc = 1'b1;
      fetch_exc_code = 5'd9; fetch_pc = 32'h00400200;
      #1;
      chk("R6 not taken", {31'b0, take_irq}, 32'h0);
      chk("R6 no redirect", {31'b0, redirect_valid}, 32'h0);
      @(negedge clk);
      fetch_valid = 1'b0; fetch_other_exc = 1'b0; fetch_exc_code = '0;
      #1;
      rd(2'd1, v); chk("R6 code written", v, 32'h00000124);
      rd(2'd2, v); chk("R6 epc", v, 32'h00400200);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_pc = 32'h00400300;
      #1;
      chk("R4 take after other", {31'b0, take_irq}, 32'h1);
      @(negedge clk); fetch_valid = 1'b0;
      #1;
      rd(2'd1, v); chk("R6 code kept by irq", v, 32'h00000124);
      @(negedge clk); irq_lines = 8'h00;
      step();
   endtask

   task automatic t_sw_write();
      logic [31:0] v;
      wr(2'd1, 32'hFFFFFFFF);
      rd(2'd1, v); chk("R8 cause pending ignored", v, 32'hFFFF00FF);
      wr(2'd1, 32'h0);
      rd(2'd1, v); chk("R8 cause cleared", v, 32'h0);
      wr(2'd2, 32'hDEADBEE0);
      rd(2'd2, v); chk("R8 epc write", v, 32'hDEADBEE0);
      wr(2'd3, 32'h80000180);
      rd(2'd3, v); chk("R8 ebase write", v, 32'h80000180);
      // interrupt entry against a status write
      @(negedge clk); irq_lines = 8'h01;
      @(negedge clk);
      reg_sel = 2'd0; reg_wdata = 32'h0000FF01; reg_wr_en = 1'b1;
      fetch_valid = 1'b1; fetch_pc = 32'h00400400;
      @(negedge clk);
      reg_wr_en = 1'b0; fetch_valid = 1'b0;
      #1;
      rd(2'd0, v); chk("R9 exl wins", v, 32'h0000FF03);
      rd(2'd2, v); chk("R9 epc from entry", v, 32'h00400400);
      // exception against a return-address write
      @(negedge clk);
      reg_sel = 2'd2; reg_wdata = 32'h11110000; reg_wr_en = 1'b1;
      fetch_valid = 1'b1; fetch_other_exc = 1'b1; fetch_exc_code = 5'd4;
      fetch_pc = 32'h00400500;
      @(negedge clk);
      reg_wr_en = 1'b0; fetch_valid = 1'b0; fetch_other_exc = 1'b0;
      #1;
      rd(2'd2, v); chk("R9 epc from exception", v, 32'h00400500);
      @(negedge clk); eret = 1'b1; irq_lines = 8'h00;
      @(negedge clk); eret = 1'b0;
      #1;
      rd(2'd0, v); chk("R7 exl cleared at end", v, 32'h0000FF01);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_pending();
      t_mask();
      t_take_ebase();
      t_take_no_ebase();
      t_other_exc();
      t_sw_write();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule